// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This unit performs signed saturating arithmetic on two 32-bit two's-complement operands. A 2-bit operation code picks one of four functions: plain add, plain subtract, and two doubling forms in which the second operand is first multiplied by two with saturation and then added to, or subtracted from, the first operand with saturation. Whenever a result cannot be represented, it is clamped to the largest or smallest signed value instead of wrapping.

The arithmetic is combinational and feeds a registered output stage. An enable input lets a new result and new saturation events into the registers; with the enable low, both outputs hold their values. A sticky flag records that at least one clamp has happened since it was last cleared. A dedicated clear input resets it. A saturation in the same cycle as a clear wins, so no event is lost. The reset input is asynchronous and active low. Its release is synchronised inside the block, so outputs leave reset two clock edges after the input rises.

Top module: `sat_addsub_unit`

## Requirements
- R1: With op = 2'b00 and enable high, the result one clock edge later equals src_a + src_b when the true sum fits in 32 signed bits, and sticky is not set by that operation.
- R2: A true result above the signed range clamps to 32'h7FFFFFFF, and one below it clamps to 32'h80000000, for every operation.
- R3: With op = 2'b01, the result is src_a - src_b, clamped as in R2.
- R4: With op = 2'b10, src_b is doubled with clamping first, and the clamped value is then added to src_a with clamping.
- R5: With op = 2'b11, src_b is doubled with clamping first, and the clamped value is then subtracted from src_a (src_a minus doubled value) with clamping.
- R6: An enabled operation whose final add or subtract clamps leaves sticky at 1 after the clock edge.
- R7: An enabled doubling operation whose doubling step clamps sets sticky, even when the final step does not clamp.
- R8: Sticky stays at 1 through later non-clamping operations. Only sticky_clr (or reset) returns it to 0. When a clamp and sticky_clr occur in the same enabled cycle, sticky ends at 1.
- R9: With en low, result and sticky keep their values, whatever the operands. A sticky_clr given with en low still clears sticky.
- R10: After reset, result reads 0 and sticky reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Loads the result register and admits saturation events |
| op | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| src_a | input | 32 | First signed operand |
| src_b | input | 32 | Second signed operand (the one doubled) |
| sticky_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered signed result |
| sticky | output | 1 | Sticky saturation flag |

## Verification
The bench goes after results that land exactly on a limit without passing it, such as 32'hFFFFFFFF minus 32'h80000000. A unit that tests overflow one bit off would clamp these or wrap them. It also covers a doubling that clamps while the following add does not, and a doubling of 32'hC0000000 that reaches 32'h80000000 exactly. A unit that ignored the first step would leave sticky at 0 or produce a wrapped sum. Subtracting 32'h80000000 and doubling it catch a design that negates the operand before extending it. Sticky is checked through non-clamping operations, a same-cycle clear and clamp, and an idle enable, where a lost event, a stuck flag or a result that changes would each show up.

// File: rtl/sat_pkg.sv
package sat_pkg;

  // Operation codes; bit 1 selects the doubling path, bit 0 selects subtract.
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;

endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  // Assertion is asynchronous; release ripples through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/sat_doubler.sv
module sat_doubler #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         clip
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // Doubling overflows exactly when the two top bits disagree.
  always_comb begin
    clip = x[W-1] ^ x[W-2];
    if (clip) begin
      y = x[W-1] ? MINV : MAXV;
    end else begin
      y = {x[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/sat_adder.sv
module sat_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         clip
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ax;
  logic [W:0] bx;
  logic [W:0] sum;

  // One guard bit holds the exact result of an add or subtract.
  always_comb begin
    ax   = {a[W-1], a};
    bx   = {b[W-1], b};
    sum  = sub ? (ax - bx) : (ax + bx);
    clip = sum[W] ^ sum[W-1];
    if (clip) begin
      y = sum[W] ? MINV : MAXV;
    end else begin
      y = sum[W-1:0];
    end
  end

endmodule

// File: rtl/sat_out_reg.sv
module sat_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] res_d,
  input  logic         sat_d,
  output logic [W-1:0] result_q,
  output logic         sticky_q
);

  logic [W-1:0] result_nxt;
  logic         sticky_nxt;

  // Next state: a saturation event outranks a clear in the same cycle.
  always_comb begin
    result_nxt = en ? res_d : result_q;
    sticky_nxt = (clr ? 1'b0 : sticky_q) | (en & sat_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      sticky_q <= 1'b0;
    end else begin
      result_q <= result_nxt;
      sticky_q <= sticky_nxt;
    end
  end

  // R6
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sat_d) |=> sticky_q);

  // R8
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_q) |-> $past(clr));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result_q));

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         sticky_clr,
  output logic [W-1:0] result,
  output logic         sticky
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  sat_op_e    op_e;
  logic       use_dbl;
  logic       do_sub;
  logic       rst_sync_n;
  logic [W-1:0] dbl_y;
  logic         dbl_clip;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum_y;
  logic         sum_clip;
  logic         sat_any;

  sat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    op_e    = sat_op_e'(op);
    use_dbl = (op_e == OP_DADD) || (op_e == OP_DSUB);
    do_sub  = (op_e == OP_SUB)  || (op_e == OP_DSUB);
  end

  sat_doubler #(.W(W)) u_dbl (
    .x    (src_b),
    .y    (dbl_y),
    .clip (dbl_clip)
  );

  assign b_eff = use_dbl ? dbl_y : src_b;

  sat_adder #(.W(W)) u_add (
    .a    (src_a),
    .b    (b_eff),
    .sub  (do_sub),
    .y    (sum_y),
    .clip (sum_clip)
  );

  // Either clamping step counts as a saturation event.
  assign sat_any = sum_clip | (use_dbl & dbl_clip);

  sat_out_reg #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (en),
    .clr      (sticky_clr),
    .res_d    (sum_y),
    .sat_d    (sat_any),
    .result_q (result),
    .sticky_q (sticky)
  );

  // R2
  clamp_extreme_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && sum_clip) |=> (result == MAXV || result == MINV));

  // R4
  dbl_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbl_clip |-> (dbl_y[W-1] == src_b[W-1]));

endmodule

// File: tb/sat_addsub_unit_tb.sv
`timescale 1ns/1ps
module sat_addsub_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [1:0]  op;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic        sticky_clr;
  logic [31:0] result;
  logic        sticky;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sat_addsub_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .op         (op),
    .src_a      (src_a),
    .src_b      (src_b),
    .sticky_clr (sticky_clr),
    .result     (result),
    .sticky     (sticky)
  );

  // {op, a, b, expected result, expected saturation}
  localparam logic [98:0] VEC [16] = '{
    {2'b00, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0},
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {2'b00, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
    {2'b00, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0},
    {2'b01, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0},
    {2'b01, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
    {2'b01, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1},
    {2'b01, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b0},
    {2'b10, 32'h00000001, 32'h00000003, 32'h00000007, 1'b0},
    {2'b10, 32'h80000000, 32'h40000000, 32'hFFFFFFFF, 1'b1},
    {2'b10, 32'h00000010, 32'hC0000000, 32'h80000010, 1'b0},
    {2'b10, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {2'b11, 32'h00000064, 32'h00000014, 32'h0000003C, 1'b0},
    {2'b11, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1},
    {2'b11, 32'hFFFFFFFF, 32'hBFFFFFFF, 32'h7FFFFFFF, 1'b1},
    {2'b11, 32'h80000000, 32'h20000000, 32'h80000000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive between edges, sample just after the loading edge.
  task automatic apply(input logic e, input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic c);
    @(negedge clk);
    en = e; op = o; src_a = a; src_b = b; sticky_clr = c;
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [1:0] o, input logic s);
    case (o)
      2'b00:   return s ? "R2 add clamp" : "R1 add";
      2'b01:   return "R3 sub";
      2'b10:   return "R4 dbl-add";
      default: return "R5 dbl-sub";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0; op = 2'b00; src_a = '0; src_b = '0; sticky_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    do_reset();
    // R10: reset state
    chk("R10 result", result, 32'h0);
    chk("R10 sticky", {31'b0, sticky}, 32'h0);

    // Table: clear asserted with every vector, so sticky shows this op alone.
    for (int i = 0; i < 16; i++) begin
      apply(1'b1, VEC[i][98:97], VEC[i][96:65], VEC[i][64:33], 1'b1);
      chk(tag_of(VEC[i][98:97], VEC[i][0]), result, VEC[i][32:1]);
      chk("R6/R7 sticky", {31'b0, sticky}, {31'b0, VEC[i][0]});
    end

    // R8: sticky survives a non-clamping op
    apply(1'b1, 2'b00, 32'h7FFFFFFF, 32'h00000005, 1'b1);
    chk("R8 set", {31'b0, sticky}, 32'h1);
    apply(1'b1, 2'b00, 32'h00000001, 32'h00000002, 1'b0);
    chk("R8 result", result, 32'h3);
    chk("R8 held", {31'b0, sticky}, 32'h1);

    // R9: idle cycle with clamping operands changes nothing; clear still works
    apply(1'b0, 2'b01, 32'h80000000, 32'h7FFFFFFF, 1'b1);
    chk("R9 result held", result, 32'h3);
    chk("R9 clear while idle", {31'b0, sticky}, 32'h0);
    apply(1'b0, 2'b10, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    chk("R9 no set while idle", {31'b0, sticky}, 32'h0);
    chk("R9 result still held", result, 32'h3);

    // R7: doubling clamp alone sets sticky without clear, then sticks
    apply(1'b1, 2'b10, 32'h80000000, 32'h40000000, 1'b0);
    chk("R7 result", result, 32'hFFFFFFFF);
    chk("R7 sticky", {31'b0, sticky}, 32'h1);
    apply(1'b1, 2'b11, 32'h00000000, 32'h00000001, 1'b0);
    chk("R5 result", result, 32'hFFFFFFFE);
    chk("R8 still set", {31'b0, sticky}, 32'h1);

    // R10: reset mid-run clears both outputs
    do_reset();
    chk("R10 result after rerun", result, 32'h0);
    chk("R10 sticky after rerun", {31'b0, sticky}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule